// File: doc/BRIEF.md
# QC-LDPC Core Parity Solver

This block computes the four core parity blocks of a quasi-cyclic LDPC code whose core parity section has the dual-diagonal shape: a first parity column of weight three, with a unit rotation in the first and last core rows. The systematic message arrives as `KB` blocks of `Z` bits, one block per accepted cycle. A four-row by `KB`-column table of rotation amounts is written beforehand through a small configuration port.

For each core row the block rotates every systematic block by that row's table entry and XORs the results into a row syndrome. It produces one row syndrome per cycle and keeps the four of them in a small memory. It then solves the parities with short XOR-and-rotate steps instead of a matrix inversion. The first parity is the XOR of all four syndromes. The second and fourth parities each combine one syndrome with the first parity rotated by one position. The third parity needs the fourth one, so it is computed one cycle later.

The four parity blocks are published together with a one-cycle `done` strobe. They hold their values until the next result.

Top module: `ldpc_core_parity`

## Requirements
- R1: After reset, `busy`, `done` and all four parity outputs are 0. Every table entry is null, so an encode run with no table writes yields all-zero parities.
- R2: A `cfg_we` pulse while idle stores `cfg_shift` at row `cfg_row` (0..3), column `cfg_col` (0..KB-1). Bit EW-1 set (EW = clog2(Z)+1) marks the entry null, meaning that column contributes nothing. Otherwise the low EW-1 bits are a rotation amount taken modulo Z, so values Z..2^(EW-1)-1 wrap.
- R3: Table writes while `busy` is high are ignored and do not change the result of the encode in progress or of later encodes.
- R4: `start` is accepted only while `busy` is low, and `busy` rises on the following cycle. A `start` while busy is ignored and produces no extra result.
- R5: After an accepted start, the first KB cycles with `blk_valid` high load blocks s1..sKB in that order. Cycles with `blk_valid` low are skipped, and `blk_valid` outside an encode is ignored.
- R6: Row syndrome i is the XOR over j of block sj rotated by entry (i,j). Rotation by P gives out[k] = in[(k+P) mod Z].
- R7: par1 equals the XOR of the four row syndromes.
- R8: par2 = syn1 ^ rot1(par1), par4 = syn4 ^ rot1(par1), par3 = syn3 ^ par4, so all four core row equations sum to zero.
- R9: `done` is high for exactly one cycle, 7 cycles after the clock edge that loads the last block, and `busy` is low in that cycle.
- R10: The parity outputs change only in a cycle where `done` is high and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_row | input | 2 | Table row (core row 1..4 as 0..3) |
| cfg_col | input | clog2(KB) | Table column (systematic block index) |
| cfg_shift | input | clog2(Z)+1 | Null flag in the top bit, rotation amount below it |
| start | input | 1 | Begin an encode |
| busy | output | 1 | An encode is in progress |
| blk_valid | input | 1 | `blk_data` carries a systematic block |
| blk_data | input | Z | Systematic block |
| done | output | 1 | One-cycle strobe: new parities are on the outputs |
| par1 | output | Z | First core parity block |
| par2 | output | Z | Second core parity block |
| par3 | output | Z | Third core parity block |
| par4 | output | Z | Fourth core parity block |

## Verification
The bench targets rotation amounts at or above Z, which would index out of range or wrap incorrectly in a solver without the modulo step. It also checks the rotation direction: a left rotation would still produce plausible-looking parities, but ones that fail the comparison against the reference model. Gapped block delivery and stray `blk_valid` pulses outside an encode would shift blocks into the wrong slots. Table writes and `start` pulses issued mid-encode would, if honoured, corrupt the current or next result, produce a second `done`, or stall the block. The bench also times `done` against the last loaded block and checks the extra row equation that the solver never evaluates directly.

// File: rtl/ldpc_core_pkg.sv
package ldpc_core_pkg;
  localparam int unsigned CORE_ROWS = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_LAM,
    ST_PA1,
    ST_PA24,
    ST_PA3
  } core_state_e;
endpackage

// File: rtl/ldpc_rot_xor.sv
// One core row: rotate every systematic block by its table entry and XOR them.
module ldpc_rot_xor #(
  parameter int Z  = 12,
  parameter int KB = 6,
  localparam int EW = $clog2(Z) + 1
) (
  input  logic [KB*Z-1:0]  sys_flat,
  input  logic [KB*EW-1:0] row_flat,
  output logic [Z-1:0]     lam
);
  function automatic logic [Z-1:0] rotate(input logic [Z-1:0] v, input logic [EW-2:0] f);
    logic [Z-1:0] r;
    int unsigned a;
    a = int'(f) % Z;
    for (int k = 0; k < Z; k++) r[k] = v[(k + a) % Z];
    return r;
  endfunction

  logic [Z-1:0] contrib [KB];

  for (genvar j = 0; j < KB; j++) begin : g_col
    logic is_null;
    assign is_null  = row_flat[j*EW + EW - 1];
    assign contrib[j] = is_null ? '0 : rotate(sys_flat[j*Z +: Z], row_flat[j*EW +: EW-1]);
  end

  always_comb begin
    lam = '0;
    for (int j = 0; j < KB; j++) lam = lam ^ contrib[j];
  end
endmodule

// File: rtl/ldpc_lambda_mem.sv
// Small register file holding the row syndromes; all words readable at once.
module ldpc_lambda_mem #(
  parameter int Z     = 12,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [Z-1:0]     wdata,
  output logic [DEPTH*Z-1:0] words
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) words <= '0;
    else if (we) words[int'(waddr)*Z +: Z] <= wdata;
  end
endmodule

// File: rtl/ldpc_core_ctrl.sv
module ldpc_core_ctrl
  import ldpc_core_pkg::*;
#(
  parameter int KB  = 6,
  localparam int CW = (KB > 1) ? $clog2(KB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          blk_valid,
  output core_state_e   state,
  output logic [CW-1:0] fill_idx,
  output logic          load_en,
  output logic [1:0]    row_idx,
  output logic          lam_we,
  output logic          busy
);
  core_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0] row_q, row_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    row_d = row_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_FILL;
        cnt_d = '0;
      end
      ST_FILL: if (blk_valid) begin
        if (cnt_q == CW'(KB - 1)) begin
          st_d  = ST_LAM;
          row_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LAM: begin
        if (row_q == 2'd3) st_d = ST_PA1;
        row_d = row_q + 1'b1;
      end
      ST_PA1:  st_d = ST_PA24;
      ST_PA24: st_d = ST_PA3;
      ST_PA3:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      row_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      row_q <= row_d;
    end
  end

  assign state    = st_q;
  assign fill_idx = cnt_q;
  assign load_en  = (st_q == ST_FILL) && blk_valid;
  assign row_idx  = row_q;
  assign lam_we   = (st_q == ST_LAM);
  assign busy     = (st_q != ST_IDLE);
endmodule

// File: rtl/ldpc_core_parity.sv
module ldpc_core_parity
  import ldpc_core_pkg::*;
#(
  parameter int Z   = 12,
  parameter int KB  = 6,
  localparam int EW = $clog2(Z) + 1,
  localparam int CW = (KB > 1) ? $clog2(KB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_row,
  input  logic [CW-1:0] cfg_col,
  input  logic [EW-1:0] cfg_shift,
  input  logic          start,
  output logic          busy,
  input  logic          blk_valid,
  input  logic [Z-1:0]  blk_data,
  output logic          done,
  output logic [Z-1:0]  par1,
  output logic [Z-1:0]  par2,
  output logic [Z-1:0]  par3,
  output logic [Z-1:0]  par4
);
  localparam int ROWW = KB * EW;
  localparam logic [EW-1:0] NULL_ENTRY = {1'b1, {(EW-1){1'b0}}};

  function automatic logic [Z-1:0] rot1(input logic [Z-1:0] v);
    return {v[0], v[Z-1:1]};
  endfunction

  core_state_e state;
  logic [CW-1:0] fill_idx;
  logic [1:0] row_idx;
  logic load_en, lam_we;
  logic [CORE_ROWS*ROWW-1:0] tbl_flat;
  logic [KB*Z-1:0] sys_q;
  logic [Z-1:0] lam_row;
  logic [CORE_ROWS*Z-1:0] lam_words;
  logic [Z-1:0] lam0, lam1, lam2, lam3;
  logic [Z-1:0] pa1_q, pa2_q, pa4_q;

  ldpc_core_ctrl #(.KB(KB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_valid(blk_valid),
    .state(state), .fill_idx(fill_idx), .load_en(load_en),
    .row_idx(row_idx), .lam_we(lam_we), .busy(busy)
  );

  // Shift table: writable only while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl_flat <= {(CORE_ROWS*KB){NULL_ENTRY}};
    else if (cfg_we && !busy && (int'(cfg_col) < KB))
      tbl_flat[(int'(cfg_row)*KB + int'(cfg_col))*EW +: EW] <= cfg_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_q <= '0;
    else if (load_en) sys_q[int'(fill_idx)*Z +: Z] <= blk_data;
  end

  ldpc_rot_xor #(.Z(Z), .KB(KB)) u_rot (
    .sys_flat(sys_q),
    .row_flat(tbl_flat[int'(row_idx)*ROWW +: ROWW]),
    .lam(lam_row)
  );

  ldpc_lambda_mem #(.Z(Z), .DEPTH(CORE_ROWS)) u_lam (
    .clk(clk), .rst_n(rst_n), .we(lam_we), .waddr(row_idx),
    .wdata(lam_row), .words(lam_words)
  );

  assign lam0 = lam_words[0*Z +: Z];
  assign lam1 = lam_words[1*Z +: Z];
  assign lam2 = lam_words[2*Z +: Z];
  assign lam3 = lam_words[3*Z +: Z];

  // Parity solve: pa1, then pa2/pa4, then pa3 and publish.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa1_q <= '0; pa2_q <= '0; pa4_q <= '0;
      par1 <= '0; par2 <= '0; par3 <= '0; par4 <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_PA1: pa1_q <= lam0 ^ lam1 ^ lam2 ^ lam3;
        ST_PA24: begin
          pa2_q <= lam0 ^ rot1(pa1_q);
          pa4_q <= lam3 ^ rot1(pa1_q);
        end
        ST_PA3: begin
          par1 <= pa1_q;
          par2 <= pa2_q;
          par3 <= lam2 ^ pa4_q;
          par4 <= pa4_q;
          done <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ldpc_core_parity_chk.sv
module ldpc_core_parity_chk #(
  parameter int Z   = 12,
  parameter int KB  = 6,
  localparam int EW = $clog2(Z) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             lam_we,
  input logic [4*KB*EW-1:0] tbl_flat,
  input logic [4*Z-1:0]   lam_words,
  input logic [Z-1:0]     par1,
  input logic [Z-1:0]     par2,
  input logic [Z-1:0]     par3,
  input logic [Z-1:0]     par4
);
  function automatic logic [Z-1:0] r1(input logic [Z-1:0] v);
    return {v[0], v[Z-1:1]};
  endfunction

  logic [Z-1:0] s1, s2, s3, s4;
  assign s1 = lam_words[0*Z +: Z];
  assign s2 = lam_words[1*Z +: Z];
  assign s3 = lam_words[2*Z +: Z];
  assign s4 = lam_words[3*Z +: Z];

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_from_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_table_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tbl_flat));
  assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({par1, par2, par3, par4}));
  assert_syn_write_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lam_we |-> busy);
  assert_pa1_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (par1 == (s1 ^ s2 ^ s3 ^ s4)));
  assert_rows_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (((s1 ^ r1(par1) ^ par2) == '0) && ((s2 ^ par1 ^ par2 ^ par3) == '0) &&
              ((s3 ^ par3 ^ par4) == '0) && ((s4 ^ r1(par1) ^ par4) == '0)));
endmodule

bind ldpc_core_parity ldpc_core_parity_chk #(.Z(Z), .KB(KB)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .lam_we(lam_we), .tbl_flat(tbl_flat), .lam_words(lam_words),
  .par1(par1), .par2(par2), .par3(par3), .par4(par4)
);

// File: tb/tb_ldpc_core_parity.sv
module tb_ldpc_core_parity;
  localparam int Z  = 12;
  localparam int KB = 6;
  localparam int EW = $clog2(Z) + 1;
  localparam int CW = $clog2(KB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_row = '0;
  logic [CW-1:0] cfg_col = '0;
  logic [EW-1:0] cfg_shift = '0;
  logic start = 1'b0;
  logic blk_valid = 1'b0;
  logic [Z-1:0] blk_data = '0;
  logic busy, done;
  logic [Z-1:0] par1, par2, par3, par4;

  always #5 clk = ~clk;

  ldpc_core_parity #(.Z(Z), .KB(KB)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_col(cfg_col),
    .cfg_shift(cfg_shift), .start(start), .busy(busy), .blk_valid(blk_valid),
    .blk_data(blk_data), .done(done), .par1(par1), .par2(par2), .par3(par3), .par4(par4)
  );

  typedef struct {
    int cyc;
    logic [Z-1:0] p1, p2, p3, p4, syn2;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int mtab [4][KB];
  logic [Z-1:0] last1 = '0, last2 = '0, last3 = '0, last4 = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [Z-1:0] mrot(input logic [Z-1:0] v, input int p);
    logic [Z-1:0] r;
    for (int k = 0; k < Z; k++) r[k] = v[(k + p) % Z];
    return r;
  endfunction

  task automatic cfg_set(input int row, input int col, input int val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_row = row[1:0];
    cfg_col = col[CW-1:0];
    cfg_shift = (val < 0) ? {1'b1, {(EW-1){1'b0}}} : {1'b0, val[EW-2:0]};
    if (!busy) mtab[row][col] = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_table(input int maxv, input int null_pct);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < KB; j++)
        cfg_set(i, j, (($urandom % 100) < null_pct) ? -1 : int'($urandom % maxv));
  endtask

  // Driver: predicts the result, drives one encode, pushes the expectation.
  task automatic encode(input bit gaps, input bit poke);
    logic [Z-1:0] blk [KB];
    logic [Z-1:0] syn [4];
    logic [Z-1:0] r;
    exp_t it;
    for (int j = 0; j < KB; j++) blk[j] = Z'($urandom);
    for (int i = 0; i < 4; i++) begin
      syn[i] = '0;
      for (int j = 0; j < KB; j++)
        if (mtab[i][j] >= 0) syn[i] ^= mrot(blk[j], mtab[i][j] % Z);
    end
    it.p1 = syn[0] ^ syn[1] ^ syn[2] ^ syn[3];
    r = mrot(it.p1, 1);
    it.p2 = syn[0] ^ r;
    it.p4 = syn[3] ^ r;
    it.p3 = syn[2] ^ it.p4;
    it.syn2 = syn[1];
    if (gaps) begin  // stray block outside an encode (R5)
      @(negedge clk);
      blk_valid = 1'b1;
      blk_data = Z'($urandom);
    end
    @(negedge clk);
    blk_valid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < KB; j++) begin
      if (gaps) begin
        int idle = $urandom % 3;
        for (int g = 0; g < idle; g++) begin
          blk_valid = 1'b0;
          blk_data = Z'($urandom);
          @(negedge clk);
        end
      end
      blk_valid = 1'b1;
      blk_data = blk[j];
      if (poke && j == 2) begin  // write while busy, must be ignored (R3)
        cfg_we = 1'b1;
        cfg_row = 2'd0;
        cfg_col = '0;
        cfg_shift = {1'b0, (EW-1)'((mtab[0][0] < 0 ? 0 : mtab[0][0] + 1) % Z)};
      end
      @(negedge clk);
      cfg_we = 1'b0;
    end
    blk_valid = 1'b0;
    it.cyc = cyc + 7;
    q.push_back(it);
    if (poke) begin  // start while busy, must be ignored (R4)
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (q.size() == 0);
    last1 = it.p1; last2 = it.p2; last3 = it.p3; last4 = it.p4;
    repeat (4) @(negedge clk);
    check({par1, par2, par3, par4} == {last1, last2, last3, last4}, "R10 hold",
          64'({par1, par2, par3, par4}), 64'({last1, last2, last3, last4}));
    check(!busy && !done, "R4 idle after done", 64'({busy, done}), 64'(0));
  endtask

  // Monitor: pops the scoreboard whenever a result appears.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R4 unexpected done", 64'(1), 64'(0));
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.cyc, "R9 done timing", 64'(cyc), 64'(e.cyc));
        check(!busy, "R9 busy low with done", 64'(busy), 64'(0));
        check(par1 == e.p1, "R7 par1", 64'(par1), 64'(e.p1));
        check(par2 == e.p2, "R8 par2", 64'(par2), 64'(e.p2));
        check(par3 == e.p3, "R8 par3", 64'(par3), 64'(e.p3));
        check(par4 == e.p4, "R8 par4", 64'(par4), 64'(e.p4));
        check((e.syn2 ^ par1 ^ par2 ^ par3) == '0, "R6 row2 equation",
              64'(e.syn2 ^ par1 ^ par2 ^ par3), 64'(0));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 64'(cyc), 64'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < KB; j++) mtab[i][j] = -1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && done == 1'b0, "R1 reset flags", 64'({busy, done}), 64'(0));
    check({par1, par2, par3, par4} == '0, "R1 reset parities", 64'({par1, par2, par3, par4}), 64'(0));
    // R1: null table after reset gives zero parities
    encode(1'b0, 1'b0);
    // R6/R7/R8: random tables, in-range rotations
    for (int t = 0; t < 4; t++) begin
      load_table(Z, 20);
      encode(1'b0, 1'b0);
      encode(1'b0, 1'b0);
    end
    // R2: rotation amounts at or above Z wrap modulo Z
    for (int t = 0; t < 2; t++) begin
      load_table(1 << (EW-1), 0);
      for (int j = 0; j < KB; j++) cfg_set(0, j, Z + (j % ((1 << (EW-1)) - Z)));
      encode(1'b0, 1'b0);
    end
    // R2: single-entry table isolates one rotation
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < KB; j++) cfg_set(i, j, -1);
    cfg_set(2, KB-1, 1);
    encode(1'b0, 1'b0);
    // R5: gapped delivery with stray valid outside an encode
    load_table(Z, 10);
    encode(1'b1, 1'b0);
    encode(1'b1, 1'b0);
    // R3/R4: table write and start while busy
    load_table(Z, 0);
    encode(1'b0, 1'b1);
    encode(1'b1, 1'b1);
    encode(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule